// File: doc/BRIEF.md
# Multi-CPU Doorbell Interrupt Unit

This unit lets the cores of a small multi-core cluster (up to eight CPUs) interrupt one another. All CPUs share one register bus. Every access carries the ID of the CPU that issues it, so one address can reach a different CPU's private state depending on who is asking.

A single write to the global trigger register raises one doorbell on any set of target CPUs. Each CPU keeps its own doorbell cause register, its own doorbell mask register and a one-bit enable for its doorbell summary source. A CPU raises its interrupt line when an enabled cause bit is pending. Its acknowledge register then returns source number 0, which is the doorbell summary. When nothing is pending, the acknowledge register returns 1023.

A global read-only control register reports how many interrupt sources the system supports. Trigger writes are staged through one register before they reach the cause registers. A cause write in the following cycle therefore cannot wipe out a doorbell that is still in flight.

Top module: `db_doorbell_unit`

## Requirements
- R1: After reset, every CPU's cause, mask and source-enable registers read 0. All `cpu_irq` bits are low, and every acknowledge read returns 1023.
- R2: A write to address 0x004 takes a doorbell number from bits [7:0] and a target CPU bitmap from bits [15:8] (bit 8+c is CPU c). Each targeted CPU gets bit n of its cause register set. Bits that are already set are kept. The new bit is visible from the second rising edge after the write is sampled.
- R3: A trigger write whose doorbell number is 8 or above, or whose target bitmap is zero, changes no cause register.
- R4: Per-CPU registers are banked. Reads and writes at 0x808 (cause), 0x80C (mask) and 0x810 (source enable, bit 0) reach only the state of the CPU given on `bus_cpu`.
- R5: A write to 0x808 replaces the issuing CPU's cause with write-data bits [7:0], so writing 0 clears every pending doorbell. A cause read returns 0 in bits [31:8].
- R6: When a staged trigger and a cause write reach the same CPU in the same cycle, the result is the written value OR the triggered bit. The trigger is never lost.
- R7: `cpu_irq[c]` is high exactly when CPU c's source-enable bit is 1 and the AND of its cause and mask registers is non-zero.
- R8: A read of 0x844 returns 0 in bits [9:0] when the issuing CPU's interrupt condition (R7) holds, and 1023 otherwise.
- R9: A read of 0x000 returns the supported source count in bits [11:2], with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_valid | input | 1 | Register access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_cpu | input | 3 | ID of the CPU issuing the access |
| bus_addr | input | 12 | Byte address; bit 11 selects the per-CPU window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, valid while a read is presented |
| cpu_irq | output | 8 | Per-CPU doorbell summary interrupt |

## Verification
The trigger path is swept over every doorbell number from 0 to 9, crossed with single-target, alternating, contiguous, full and empty bitmaps. Each issuing CPU differs from the targets in most cases. After each write, the cause register of all eight CPUs is read back. This separates correct fan-out from stray bits, shows that pending bits accumulate, and confirms that out-of-range or empty triggers have no effect. Distinct mask values are written from every CPU and read back, which exposes any bank cross-talk. Cause patterns with and without mask overlap, with the source enable on and off, separate the interrupt and acknowledge logic from the plain cause state. Back-to-back trigger and cause writes to the same CPU show whether the staged doorbell survives a same-cycle clear.

// File: rtl/db_pkg.sv
package db_pkg;
  localparam int ADDR_W = 12;
  localparam int SRC_W  = 10;
  localparam int TGT_LSB = 8;
  localparam int NUM_LSB = 0;
  localparam int NUM_W   = 8;

  localparam logic [ADDR_W-1:0] A_CTRL  = 12'h000;
  localparam logic [ADDR_W-1:0] A_TRIG  = 12'h004;
  localparam logic [ADDR_W-1:0] A_CAUSE = 12'h808;
  localparam logic [ADDR_W-1:0] A_MASK  = 12'h80C;
  localparam logic [ADDR_W-1:0] A_SRCEN = 12'h810;
  localparam logic [ADDR_W-1:0] A_ACK   = 12'h844;

  localparam logic [SRC_W-1:0] SRC_NONE = 10'd1023;
  localparam logic [SRC_W-1:0] SRC_BELL = 10'd0;
endpackage

// File: rtl/db_trig.sv
module db_trig #(
  parameter int NUM_CPU  = 8,
  parameter int NUM_BELL = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               trig_we,
  input  logic [15:0]                        trig_data,
  output logic [NUM_CPU-1:0][NUM_BELL-1:0]   set_vec
);
  import db_pkg::*;
  localparam int BELL_W = $clog2(NUM_BELL);

  logic               stg_vld, stg_vld_nxt;
  logic [NUM_CPU-1:0] stg_tgt, stg_tgt_nxt;
  logic [BELL_W-1:0]  stg_num, stg_num_nxt;
  logic [NUM_CPU-1:0] req_tgt;
  logic               num_ok, accept;

  always_comb begin
    req_tgt     = trig_data[TGT_LSB +: NUM_CPU];
    num_ok      = trig_data[NUM_LSB +: NUM_W] < NUM_W'(NUM_BELL);
    accept      = trig_we && num_ok && (|req_tgt);
    stg_vld_nxt = accept;
    stg_tgt_nxt = accept ? req_tgt : stg_tgt;
    stg_num_nxt = accept ? trig_data[NUM_LSB +: BELL_W] : stg_num;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_vld <= 1'b0;
      stg_tgt <= '0;
      stg_num <= '0;
    end else begin
      stg_vld <= stg_vld_nxt;
      if (accept) begin
        stg_tgt <= stg_tgt_nxt;
        stg_num <= stg_num_nxt;
      end
    end
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_fan
    assign set_vec[c] = (stg_vld && stg_tgt[c]) ? (NUM_BELL'(1) << stg_num) : '0;
  end

  // R3: out-of-range doorbell number raises nothing
  p_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_we && trig_data[7:0] >= 8'(NUM_BELL)) |=> (set_vec == '0));

  // R2: one set bit per targeted CPU
  p_fanout_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_we && trig_data[7:0] < 8'(NUM_BELL)) |=>
      ($countones(set_vec) == $countones($past(trig_data[TGT_LSB +: NUM_CPU]))));
endmodule

// File: rtl/db_bank.sv
module db_bank #(
  parameter int NUM_BELL = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cause_we,
  input  logic                mask_we,
  input  logic                en_we,
  input  logic [NUM_BELL-1:0] wdata,
  input  logic                en_in,
  input  logic [NUM_BELL-1:0] set_vec,
  output logic [NUM_BELL-1:0] cause,
  output logic [NUM_BELL-1:0] mask,
  output logic                src_en,
  output logic                irq
);
  logic [NUM_BELL-1:0] cause_nxt, mask_nxt;
  logic                en_nxt;

  always_comb begin
    cause_nxt = (cause_we ? wdata : cause) | set_vec;
    mask_nxt  = mask_we ? wdata : mask;
    en_nxt    = en_we ? en_in : src_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause  <= '0;
      mask   <= '0;
      src_en <= 1'b0;
    end else begin
      cause <= cause_nxt;
      if (mask_we) mask   <= mask_nxt;
      if (en_we)   src_en <= en_nxt;
    end
  end

  assign irq = src_en && (|(cause & mask));

  // R6: a staged doorbell always lands
  p_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((cause & $past(set_vec)) == $past(set_vec)));

  // R5: clean clear write empties the cause
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_we && wdata == '0 && set_vec == '0) |=> (cause == '0));

  // R2: pending bits are sticky without a cause write
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cause_we) |=> ((cause & $past(cause)) == $past(cause)));

  // R1: nothing pending on reset release
  p_rst_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cause == '0 && !irq));
endmodule

// File: rtl/db_doorbell_unit.sv
module db_doorbell_unit #(
  parameter int NUM_CPU  = 8,
  parameter int NUM_BELL = 8,
  parameter int NUM_SRC  = 116,
  parameter int CPU_W    = $clog2(NUM_CPU)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_valid,
  input  logic                      bus_write,
  input  logic [CPU_W-1:0]          bus_cpu,
  input  logic [db_pkg::ADDR_W-1:0] bus_addr,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  output logic [NUM_CPU-1:0]        cpu_irq
);
  import db_pkg::*;

  logic [1:0] rst_sync;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  logic wr, rd, trig_we;
  logic [NUM_CPU-1:0][NUM_BELL-1:0] set_vec;
  logic [NUM_CPU-1:0][NUM_BELL-1:0] cause_a, mask_a;
  logic [NUM_CPU-1:0] en_a;
  logic [NUM_CPU-1:0] cause_we, mask_we, en_we;
  logic unused_hi;

  assign wr        = bus_valid && bus_write;
  assign rd        = bus_valid && !bus_write;
  assign trig_we   = wr && (bus_addr == A_TRIG);
  assign unused_hi = ^bus_wdata[31:16];

  db_trig #(.NUM_CPU(NUM_CPU), .NUM_BELL(NUM_BELL)) u_trig (
    .clk(clk), .rst_n(rst_q), .trig_we(trig_we),
    .trig_data(bus_wdata[15:0]), .set_vec(set_vec)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic sel;
    assign sel         = (bus_cpu == CPU_W'(c));
    assign cause_we[c] = wr && sel && (bus_addr == A_CAUSE);
    assign mask_we[c]  = wr && sel && (bus_addr == A_MASK);
    assign en_we[c]    = wr && sel && (bus_addr == A_SRCEN);

    db_bank #(.NUM_BELL(NUM_BELL)) u_bank (
      .clk(clk), .rst_n(rst_q),
      .cause_we(cause_we[c]), .mask_we(mask_we[c]), .en_we(en_we[c]),
      .wdata(bus_wdata[NUM_BELL-1:0]), .en_in(bus_wdata[0]),
      .set_vec(set_vec[c]),
      .cause(cause_a[c]), .mask(mask_a[c]), .src_en(en_a[c]),
      .irq(cpu_irq[c])
    );
  end

  logic [SRC_W-1:0] src_cnt;
  assign src_cnt = SRC_W'(NUM_SRC);

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      unique case (bus_addr)
        A_CTRL:  bus_rdata = {{(32-SRC_W-2){1'b0}}, src_cnt, 2'b00};
        A_CAUSE: bus_rdata = 32'(cause_a[bus_cpu]);
        A_MASK:  bus_rdata = 32'(mask_a[bus_cpu]);
        A_SRCEN: bus_rdata = 32'(en_a[bus_cpu]);
        A_ACK:   bus_rdata = 32'(cpu_irq[bus_cpu] ? SRC_BELL : SRC_NONE);
        default: bus_rdata = '0;
      endcase
    end
  end

  // R8: acknowledge names the doorbell source while an interrupt is up
  p_ack_r8: assert property (@(posedge clk) disable iff (!rst_q)
    (rd && bus_addr == A_ACK && cpu_irq[bus_cpu]) |-> (bus_rdata[SRC_W-1:0] == SRC_BELL));

  // R7: no interrupt on a CPU whose summary source is disabled
  p_irq_en_r7: assert property (@(posedge clk) disable iff (!rst_q)
    (cpu_irq & ~en_a) == '0);
endmodule

// File: tb/tb_db_doorbell_unit.sv
`timescale 1ns/1ps
module tb_db_doorbell_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_valid, bus_write;
  logic [2:0]  bus_cpu;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [7:0]  cpu_irq;

  int checks = 0;
  int fails  = 0;
  logic [7:0] m_cause [8];
  logic [7:0] m_mask  [8];
  logic       m_en    [8];

  always #10 clk = ~clk;

  db_doorbell_unit dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_cpu(bus_cpu), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int cpu, input logic [11:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_cpu = 3'(cpu); bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input int cpu, input logic [11:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_cpu = 3'(cpu); bus_addr = a;
    #2 d = bus_rdata;
    #1 bus_valid = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic exp_irq(input int c);
    return m_en[c] && ((m_cause[c] & m_mask[c]) != 8'h00);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [7:0] tgts [7] = '{8'h01, 8'h80, 8'h55, 8'hAA, 8'hFF, 8'h00, 8'h3C};
    bus_valid = 0; bus_write = 0; bus_cpu = 0; bus_addr = 0; bus_wdata = 0;
    rst_n = 1'b0;
    for (int c = 0; c < 8; c++) begin m_cause[c] = 0; m_mask[c] = 0; m_en[c] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 irq", 32'(cpu_irq), 32'h0);
    for (int c = 0; c < 8; c++) begin
      rd(c, 12'h808, d); check("R1 cause", d, 32'h0);
      rd(c, 12'h80C, d); check("R1 mask", d, 32'h0);
      rd(c, 12'h810, d); check("R1 srcen", d, 32'h0);
      rd(c, 12'h844, d); check("R1 ack", d, 32'd1023);
    end

    // R9 control register
    rd(5, 12'h000, d); check("R9 control", d, 32'(116) << 2);

    // R2 / R3 trigger sweep
    for (int b = 0; b < 10; b++) begin
      for (int t = 0; t < 7; t++) begin
        wr(b % 8, 12'h004, {16'h0, tgts[t], 8'(b)});
        tick();
        if (b < 8)
          for (int c = 0; c < 8; c++) if (tgts[t][c]) m_cause[c][b] = 1'b1;
        for (int c = 0; c < 8; c++) begin
          rd(c, 12'h808, d);
          if (b >= 8 || tgts[t] == 8'h00) check("R3 ignored trigger", d, 32'(m_cause[c]));
          else check("R2 trigger fan-out", d, 32'(m_cause[c]));
        end
      end
      for (int c = 0; c < 8; c++) begin wr(c, 12'h808, 32'h0); m_cause[c] = 0; end
    end

    // R4 banking
    for (int c = 0; c < 8; c++) begin
      m_mask[c] = 8'((c * 37 + 5) & 8'hFF);
      wr(c, 12'h80C, 32'(m_mask[c]));
    end
    for (int c = 0; c < 8; c++) begin
      rd(c, 12'h80C, d); check("R4 banked mask", d, 32'(m_mask[c]));
      rd(c, 12'h808, d); check("R4 banked cause", d, 32'h0);
    end
    wr(3, 12'h810, 32'h1); m_en[3] = 1'b1;
    for (int c = 0; c < 8; c++) begin
      rd(c, 12'h810, d); check("R4 banked srcen", d, 32'(m_en[c]));
    end

    // R5 cause write semantics
    wr(2, 12'h808, 32'hA5); rd(2, 12'h808, d); check("R5 cause write", d, 32'hA5);
    wr(2, 12'h808, 32'hFFFFFF3C); rd(2, 12'h808, d); check("R5 upper bits", d, 32'h3C);
    rd(1, 12'h808, d); check("R5 other cpu", d, 32'h0);
    wr(2, 12'h808, 32'h0); rd(2, 12'h808, d); check("R5 clear", d, 32'h0);

    // R7 / R8 interrupt and acknowledge
    for (int c = 0; c < 8; c++) begin wr(c, 12'h810, 32'h1); m_en[c] = 1'b1; end
    for (int p = 0; p < 5; p++) begin
      logic [7:0] pat;
      pat = (p == 0) ? 8'h00 : (p == 1) ? 8'h01 : (p == 2) ? 8'h80 : (p == 3) ? 8'hF0 : 8'h0F;
      for (int c = 0; c < 8; c++) begin wr(c, 12'h808, 32'(pat)); m_cause[c] = pat; end
      for (int c = 0; c < 8; c++) begin
        check("R7 irq", 32'(cpu_irq[c]), 32'(exp_irq(c)));
        rd(c, 12'h844, d); check("R8 ack", d, exp_irq(c) ? 32'd0 : 32'd1023);
      end
    end
    for (int c = 0; c < 8; c++) begin wr(c, 12'h808, 32'hFF); m_cause[c] = 8'hFF; end
    for (int c = 0; c < 8; c += 2) begin wr(c, 12'h810, 32'h0); m_en[c] = 1'b0; end
    for (int c = 0; c < 8; c++) begin
      check("R7 srcen gate", 32'(cpu_irq[c]), 32'(exp_irq(c)));
      rd(c, 12'h844, d); check("R8 ack gated", d, exp_irq(c) ? 32'd0 : 32'd1023);
    end
    for (int c = 0; c < 8; c++) begin wr(c, 12'h808, 32'h0); m_cause[c] = 0; end

    // R6 collision of staged trigger with cause write
    wr(0, 12'h004, 32'h0805);
    wr(3, 12'h808, 32'h0);
    rd(3, 12'h808, d); check("R6 trigger kept over clear", d, 32'h20);
    wr(0, 12'h004, 32'h0801);
    wr(3, 12'h808, 32'h04);
    rd(3, 12'h808, d); check("R6 trigger merged with write", d, 32'h06);
    wr(7, 12'h004, 32'h1802);
    wr(4, 12'h808, 32'h0);
    rd(4, 12'h808, d); check("R6 second target kept", d, 32'h04);
    rd(3, 12'h808, d); check("R6 first target", d, 32'h06);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule